// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the coherence controller that sits beside one processor's small direct-mapped cache on a shared snooping bus. Each cache line holds one word. A resident line is in one of three coherence states: exclusive clean, shared clean, or dirty (the only copy, modified since it was fetched). A separate valid bit marks whether a line is present at all. Coherence is kept by update rather than invalidation. A store to a shared line goes out on the bus as an update, and that update refreshes the peer copies and main memory together. As a result, shared lines are never stale with respect to memory. Only a dirty line ever needs a write-back.

On the processor side, a request is held with `cpu_valid` until the controller raises `cpu_ready` for one cycle. A read returns its data in that same cycle. On the bus side, the controller raises `bus_req` with a command, an address and write data, and holds them until a one-cycle `bus_ack` arrives. In that acknowledge cycle it samples `bus_rdata` and the wired-OR `bus_shared` input. The snoop side presents another cache's transaction. The controller answers combinationally with its contribution to the shared line (`snp_shared`) and, when it owns dirty data, with `snp_supply` and `snp_data`. The state change from a snoop takes effect at the next clock edge.

Top module: `cc_update_cache`

## Requirements
- R1: After synchronous reset every line is absent: `bus_req` and `cpu_ready` are low while idle, and a snooped read of any address leaves `snp_shared` low.
- R2: A read miss with no other holder issues one bus read (command code 0) and fills the line exclusive clean. The processor receives the memory word, and a later store to the line completes without bus traffic.
- R3: A read miss during which `bus_shared` is sampled high in the acknowledge cycle fills the line as shared. The next store to it issues a bus update.
- R4: A store that hits an exclusive-clean or dirty line writes the data locally, leaves or makes the line dirty, and issues no bus transaction.
- R5: A store that hits a shared line issues a bus update (command code 1) carrying the address and the new data, which memory also takes. Afterwards the line is shared if `bus_shared` was high at the acknowledge, and exclusive clean otherwise.
- R6: A miss whose index holds a dirty line first writes the old line back (command code 2, address formed from the old tag and the index, which is `addr[2:0]` by default), then reads the new line. A clean victim is dropped with no write-back.
- R7: `snp_shared` is high only for a snooped read or update (codes 0 or 1) whose address matches a present line. A tag mismatch or a snooped write-back (code 2) leaves it low.
- R8: A snooped read of a dirty line raises `snp_supply` with the line's data on `snp_data`, and the line becomes shared.
- R9: A snooped update of a shared line replaces the local data and leaves the line shared.
- R10: A store miss runs as a bus read followed by the store-hit behaviour for the state the fill produced.
- R11: `cpu_ready` stays low until any required bus transaction is acknowledged. A read hit completes in the cycle it is presented. `bus_req`, `bus_cmd` and `bus_addr` stay stable until `bus_ack`.
- R12: A snooped read of an exclusive-clean line raises `snp_shared` without `snp_supply`, and the line becomes shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Own bus transaction pending |
| bus_cmd | output | 2 | 0 read, 1 update, 2 write-back, 3 none |
| bus_addr | output | ADDR_W | Address of own transaction |
| bus_wdata | output | DATA_W | Data for update or write-back |
| bus_ack | input | 1 | One-cycle completion of own transaction |
| bus_rdata | input | DATA_W | Read data, sampled with `bus_ack` |
| bus_shared | input | 1 | Wired-OR shared line, sampled with `bus_ack` |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_cmd | input | 2 | Peer command, same codes as `bus_cmd` |
| snp_addr | input | ADDR_W | Peer address |
| snp_wdata | input | DATA_W | Peer update data |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies dirty data for a snooped read |
| snp_data | output | DATA_W | Data supplied with `snp_supply` |

## Verification
A wrong coherence state can stay hidden until the line is next stored to or snooped. A line that is exclusive when it should be shared shows up as a missing bus update on the following store. A line that is shared when it should be dirty shows up as a missing `snp_supply` on the next snooped read. A lost dirty bit shows up only at eviction, as a missing write-back. Each scenario therefore follows its state-changing event with a store, a snoop or a conflicting miss, and reads the bus transaction counts and the supplied data at the ports within a few cycles.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        CS_EXCL  = 2'd0,
        CS_SHRD  = 2'd1,
        CS_DIRTY = 2'd2
    } coh_state_e;

    typedef enum logic [1:0] {
        BC_READ   = 2'd0,
        BC_UPDATE = 2'd1,
        BC_WBACK  = 2'd2,
        BC_NONE   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_WBACK = 2'd1,
        M_FILL  = 2'd2,
        M_UPD   = 2'd3
    } master_state_e;

    // state a line takes once its own bus transaction has seen the shared line
    function automatic coh_state_e state_after_bus(input logic shared_seen);
        return shared_seen ? CS_SHRD : CS_EXCL;
    endfunction

    function automatic logic cmd_probes_holders(input bus_cmd_e cmd);
        return (cmd == BC_READ) || (cmd == BC_UPDATE);
    endfunction

endpackage

// File: rtl/cc_line_store.sv
module cc_line_store
    import cc_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    // lookup port for the processor side
    input  logic [IDX_W-1:0]  p_idx,
    output logic              p_vld,
    output logic [TAG_W-1:0]  p_tag,
    output logic [DATA_W-1:0] p_data,
    output coh_state_e        p_st,
    // lookup port for the snoop side
    input  logic [IDX_W-1:0]  s_idx,
    output logic              s_vld,
    output logic [TAG_W-1:0]  s_tag,
    output logic [DATA_W-1:0] s_data,
    output coh_state_e        s_st,
    // processor-side write: installs a whole line
    input  logic              pw_en,
    input  logic [TAG_W-1:0]  pw_tag,
    input  logic [DATA_W-1:0] pw_data,
    input  coh_state_e        pw_st,
    // snoop-side write: state, optionally data
    input  logic              sw_en,
    input  logic              sw_data_en,
    input  logic [DATA_W-1:0] sw_data,
    input  coh_state_e        sw_st
);

    typedef struct packed {
        logic              vld;
        coh_state_e        st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t lines_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                lines_q[i].vld <= 1'b0;
                lines_q[i].st  <= CS_EXCL;
            end
        end else begin
            if (sw_en) begin
                lines_q[s_idx].st <= sw_st;
                if (sw_data_en)
                    lines_q[s_idx].data <= sw_data;
            end
            // processor side wins when both touch the same index
            if (pw_en) begin
                lines_q[p_idx].vld  <= 1'b1;
                lines_q[p_idx].st   <= pw_st;
                lines_q[p_idx].tag  <= pw_tag;
                lines_q[p_idx].data <= pw_data;
            end
        end
    end

    assign p_vld  = lines_q[p_idx].vld;
    assign p_tag  = lines_q[p_idx].tag;
    assign p_data = lines_q[p_idx].data;
    assign p_st   = lines_q[p_idx].st;
    assign s_vld  = lines_q[s_idx].vld;
    assign s_tag  = lines_q[s_idx].tag;
    assign s_data = lines_q[s_idx].data;
    assign s_st   = lines_q[s_idx].st;

endmodule

// File: rtl/cc_snoop.sv
module cc_snoop
    import cc_pkg::*;
#(
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  bus_cmd_e          cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              line_vld,
    input  logic [TAG_W-1:0]  line_tag,
    input  coh_state_e        line_st,
    input  logic [DATA_W-1:0] line_data,
    output logic              shared,
    output logic              supply,
    output logic [DATA_W-1:0] supply_data,
    output logic              st_we,
    output logic              data_we,
    output coh_state_e        new_st
);

    logic held;

    assign held        = snp_valid && line_vld && (line_tag == snp_tag);
    assign shared      = held && cmd_probes_holders(cmd);
    assign supply      = held && (cmd == BC_READ) && (line_st == CS_DIRTY);
    assign supply_data = line_data;
    // any probe of a held line leaves it shared; an update also carries data
    assign st_we       = shared;
    assign data_we     = held && (cmd == BC_UPDATE);
    assign new_st      = CS_SHRD;

endmodule

// File: rtl/cc_master.sv
module cc_master
    import cc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    input  logic              line_vld,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    input  coh_state_e        line_st,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output coh_state_e        wr_st
);

    master_state_e state_q, state_d;
    logic          hit;
    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;

    assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign req_idx = cpu_addr[IDX_W-1:0];
    assign hit     = line_vld && (line_tag == req_tag);

    always_ff @(posedge clk) begin
        if (rst) state_q <= M_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        wr_en     = 1'b0;
        wr_data   = cpu_wdata;
        wr_st     = CS_DIRTY;
        unique case (state_q)
            M_IDLE: begin
                if (cpu_valid) begin
                    if (hit) begin
                        if (!cpu_write) begin
                            cpu_ready = 1'b1;
                        end else if (line_st != CS_SHRD) begin
                            cpu_ready = 1'b1;
                            wr_en     = 1'b1;
                        end else begin
                            state_d = M_UPD;
                        end
                    end else if (line_vld && line_st == CS_DIRTY) begin
                        state_d = M_WBACK;
                    end else begin
                        state_d = M_FILL;
                    end
                end
            end
            M_WBACK: begin
                bus_req   = 1'b1;
                bus_cmd   = BC_WBACK;
                bus_addr  = {line_tag, req_idx};
                bus_wdata = line_data;
                if (bus_ack) state_d = M_FILL;
            end
            M_FILL: begin
                bus_req = 1'b1;
                bus_cmd = BC_READ;
                if (bus_ack) begin
                    wr_en   = 1'b1;
                    wr_data = bus_rdata;
                    wr_st   = state_after_bus(bus_shared);
                    state_d = M_IDLE;
                end
            end
            M_UPD: begin
                bus_req = 1'b1;
                bus_cmd = BC_UPDATE;
                if (bus_ack) begin
                    wr_en     = 1'b1;
                    wr_st     = state_after_bus(bus_shared);
                    cpu_ready = 1'b1;
                    state_d   = M_IDLE;
                end
            end
            default: state_d = M_IDLE;
        endcase
    end

endmodule

// File: rtl/cc_update_cache.sv
module cc_update_cache
    import cc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_wdata,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);

    logic              p_vld, s_vld;
    logic [TAG_W-1:0]  p_tag, s_tag;
    logic [DATA_W-1:0] p_data, s_data;
    coh_state_e        p_st, s_st;
    logic              pw_en, sw_en, sw_data_en;
    logic [DATA_W-1:0] pw_data;
    coh_state_e        pw_st, sw_st;
    bus_cmd_e          m_cmd;

    cc_line_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .p_idx(cpu_addr[IDX_W-1:0]),
        .p_vld(p_vld), .p_tag(p_tag), .p_data(p_data), .p_st(p_st),
        .s_idx(snp_addr[IDX_W-1:0]),
        .s_vld(s_vld), .s_tag(s_tag), .s_data(s_data), .s_st(s_st),
        .pw_en(pw_en), .pw_tag(cpu_addr[ADDR_W-1:IDX_W]),
        .pw_data(pw_data), .pw_st(pw_st),
        .sw_en(sw_en), .sw_data_en(sw_data_en),
        .sw_data(snp_wdata), .sw_st(sw_st)
    );

    cc_master #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_master (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .line_vld(p_vld), .line_tag(p_tag), .line_data(p_data), .line_st(p_st),
        .bus_req(bus_req), .bus_cmd(m_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_shared(bus_shared),
        .wr_en(pw_en), .wr_data(pw_data), .wr_st(pw_st)
    );

    cc_snoop #(
        .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_snoop (
        .snp_valid(snp_valid), .cmd(bus_cmd_e'(snp_cmd)),
        .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .line_vld(s_vld), .line_tag(s_tag), .line_st(s_st), .line_data(s_data),
        .shared(snp_shared), .supply(snp_supply), .supply_data(snp_data),
        .st_we(sw_en), .data_we(sw_data_en), .new_st(sw_st)
    );

    assign bus_cmd   = m_cmd;
    assign cpu_rdata = p_data;

endmodule

// File: rtl/cc_update_cache_chk.sv
module cc_update_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_shared,
    input logic              snp_supply
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R11
    ready_waits_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && bus_req) |-> bus_ack);

    // R6
    wback_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && bus_cmd == 2'd2) |=> (bus_req && bus_cmd == 2'd0));

    // R7
    wback_not_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == 2'd2) |-> !snp_shared);

    // R8
    supply_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        snp_supply |-> (snp_shared && snp_cmd == 2'd0));

endmodule

bind cc_update_cache cc_update_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_shared(snp_shared), .snp_supply(snp_supply)
);

// File: tb/sim_cc_update_cache.sv
`timescale 1ns/1ps
module sim_cc_update_cache;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_shared = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd3;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_wdata = '0;
    logic          snp_shared, snp_supply;
    logic [DW-1:0] snp_data;

    always #2 clk = ~clk;

    cc_update_cache u0 (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_wdata(snp_wdata), .snp_shared(snp_shared),
        .snp_supply(snp_supply), .snp_data(snp_data)
    );

    int nchk = 0, nerr = 0;
    int n_rd = 0, n_upd = 0, n_wb = 0;
    logic [AW-1:0] upd_a, wb_a;
    logic [DW-1:0] upd_d, wb_d;
    logic          peer_sh = 1'b0;
    logic [DW-1:0] mem [0:(1<<AW)-1];

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder and peer shared line
    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = 32'h5000_0000 + i * 7;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req && !rst) begin
                case (bus_cmd)
                    2'd0: begin bus_rdata = mem[bus_addr]; n_rd++; end
                    2'd1: begin mem[bus_addr] = bus_wdata; upd_a = bus_addr; upd_d = bus_wdata; n_upd++; end
                    2'd2: begin mem[bus_addr] = bus_wdata; wb_a = bus_addr; wb_d = bus_wdata; n_wb++; end
                    default: ;
                endcase
                bus_shared = peer_sh;
                bus_ack = 1'b1;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int waits);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #1;
        while (!cpu_ready && waits < 1000) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_valid = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic sh, output logic sup, output logic [DW-1:0] sd);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a; snp_wdata = d;
        #1;
        sh = snp_shared; sup = snp_supply; sd = snp_data;
        @(posedge clk); #1;
        snp_valid = 1'b0; snp_cmd = 2'd3;
    endtask

    task automatic t_reset();
        logic sh, sup; logic [DW-1:0] sd;
        do_reset();
        #1;
        chk("R1 ready idle", cpu_ready, 0);
        chk("R1 bus idle", bus_req, 0);
        snoop(2'd0, 12'h010, 0, sh, sup, sd);
        chk("R1 empty snoop shared", sh, 0);
    endtask

    task automatic t_read_excl();
        logic [DW-1:0] rd, sd; int w; int r0, u0c; logic sh, sup;
        do_reset(); peer_sh = 0;
        r0 = n_rd;
        access(0, 12'h010, 0, rd, w);
        chk("R2 miss data", rd, mem[12'h010]);
        chk("R2 one read", n_rd - r0, 1);
        r0 = n_rd;
        access(0, 12'h010, 0, rd, w);
        chk("R11 read hit no wait", w, 0);
        chk("R11 read hit no bus", n_rd - r0, 0);
        u0c = n_upd;
        access(1, 12'h010, 32'hAAAA_0001, rd, w);
        chk("R4 excl store silent", n_upd - u0c, 0);
        snoop(2'd0, 12'h010, 0, sh, sup, sd);
        chk("R8 dirty snoop shared", sh, 1);
        chk("R8 dirty supply", sup, 1);
        chk("R8 supply data", sd, 32'hAAAA_0001);
        u0c = n_upd;
        access(1, 12'h010, 32'hAAAA_0002, rd, w);
        chk("R8 now shared, store updates", n_upd - u0c, 1);
        chk("R5 update addr", upd_a, 12'h010);
        chk("R5 update data", upd_d, 32'hAAAA_0002);
        chk("R5 memory written", mem[12'h010], 32'hAAAA_0002);
        chk("R11 update store waited", (w > 0), 1);
    endtask

    task automatic t_read_shared();
        logic [DW-1:0] rd; int w; int u0c;
        do_reset(); peer_sh = 1;
        access(0, 12'h021, 0, rd, w);
        chk("R3 shared fill data", rd, mem[12'h021]);
        u0c = n_upd;
        access(1, 12'h021, 32'hBBBB_0001, rd, w);
        chk("R3 store to shared fill updates", n_upd - u0c, 1);
        u0c = n_upd;
        access(1, 12'h021, 32'hBBBB_0002, rd, w);
        chk("R5 stays shared while peer holds", n_upd - u0c, 1);
        peer_sh = 0;
        u0c = n_upd;
        access(1, 12'h021, 32'hBBBB_0003, rd, w);
        chk("R5 update with no peer", n_upd - u0c, 1);
        u0c = n_upd;
        access(1, 12'h021, 32'hBBBB_0004, rd, w);
        chk("R5 became exclusive, silent store", n_upd - u0c, 0);
        access(0, 12'h021, 0, rd, w);
        chk("R4 local data kept", rd, 32'hBBBB_0004);
    endtask

    task automatic t_evict();
        logic [DW-1:0] rd; int w; int r0, b0;
        do_reset(); peer_sh = 0;
        access(0, 12'h032, 0, rd, w);
        access(1, 12'h032, 32'hCCCC_0001, rd, w);
        r0 = n_rd; b0 = n_wb;
        access(0, 12'h03A, 0, rd, w);
        chk("R6 dirty victim written back", n_wb - b0, 1);
        chk("R6 write-back addr", wb_a, 12'h032);
        chk("R6 write-back data", wb_d, 32'hCCCC_0001);
        chk("R6 then one read", n_rd - r0, 1);
        chk("R6 new line data", rd, mem[12'h03A]);
        r0 = n_rd; b0 = n_wb;
        access(0, 12'h032, 0, rd, w);
        chk("R6 clean victim dropped", n_wb - b0, 0);
        chk("R6 refetched data", rd, 32'hCCCC_0001);
    endtask

    task automatic t_snoop();
        logic [DW-1:0] rd, sd; int w; int r0, u0c; logic sh, sup;
        do_reset(); peer_sh = 1;
        access(0, 12'h043, 0, rd, w);
        snoop(2'd1, 12'h043, 32'hDDDD_0001, sh, sup, sd);
        chk("R7 update probe shared", sh, 1);
        chk("R9 update no supply", sup, 0);
        r0 = n_rd;
        access(0, 12'h043, 0, rd, w);
        chk("R9 data replaced", rd, 32'hDDDD_0001);
        chk("R9 read hit no bus", n_rd - r0, 0);
        u0c = n_upd;
        access(1, 12'h043, 32'hDDDD_0002, rd, w);
        chk("R9 line still shared", n_upd - u0c, 1);
        snoop(2'd2, 12'h043, 0, sh, sup, sd);
        chk("R7 write-back not shared", sh, 0);
        snoop(2'd0, 12'h04B, 0, sh, sup, sd);
        chk("R7 tag mismatch not shared", sh, 0);
        do_reset(); peer_sh = 0;
        access(0, 12'h054, 0, rd, w);
        snoop(2'd0, 12'h054, 0, sh, sup, sd);
        chk("R12 exclusive snoop shared", sh, 1);
        chk("R12 exclusive no supply", sup, 0);
        u0c = n_upd;
        access(1, 12'h054, 32'hEEEE_0001, rd, w);
        chk("R12 line became shared", n_upd - u0c, 1);
    endtask

    task automatic t_store_miss();
        logic [DW-1:0] rd, sd; int w; int r0, u0c; logic sh, sup;
        do_reset(); peer_sh = 0;
        r0 = n_rd; u0c = n_upd;
        access(1, 12'h065, 32'hF0F0_0001, rd, w);
        chk("R10 miss read", n_rd - r0, 1);
        chk("R10 exclusive fill no update", n_upd - u0c, 0);
        snoop(2'd0, 12'h065, 0, sh, sup, sd);
        chk("R10 stored line dirty", sup, 1);
        chk("R10 stored data", sd, 32'hF0F0_0001);
        peer_sh = 1;
        r0 = n_rd; u0c = n_upd;
        access(1, 12'h076, 32'hF0F0_0002, rd, w);
        chk("R10 shared miss read", n_rd - r0, 1);
        chk("R10 shared miss update", n_upd - u0c, 1);
        chk("R10 memory holds store", mem[12'h076], 32'hF0F0_0002);
        access(0, 12'h076, 0, rd, w);
        chk("R10 local data", rd, 32'hF0F0_0002);
        chk("R11 hit after store no wait", w, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        nchk++; nerr++;
        $display("FAIL R11 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_read_excl();
        t_read_shared();
        t_evict();
        t_snoop();
        t_store_miss();
        finish_run();
    end

endmodule